// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block produces the multiplexed external memory bus timing of a classic 8-bit controller. It runs off the oscillator clock and splits time into machine cycles of twelve clocks. Each cycle has six states of two phases, numbered 0 to 11 from reset. For each cycle the sequencer decides the kind of bus activity. From that kind and the phase it drives the address latch strobe `ale`, the code-read strobe `psen_n`, the data strobes `rd_n` and `wr_n`, the shared low address/data port (`p0_out`, `p0_oe`, `p0_in`) and the high-address port `p2_out`.

The core asks for work with a one-clock `req` pulse that carries a kind code, a 16-bit address and write data. The request is held until the next machine-cycle boundary and is then run as one complete cycle. The sequencer answers with a one-clock `done` pulse in the first clock of the following cycle. When the cycle read something, the captured bytes on `rdata` are valid together with that pulse.

The FSM (`bseq_cycle_fsm`) has four states, each lasting one whole machine cycle: `CYC_IDLE`, `CYC_FETCH`, `CYC_READ` and `CYC_WRITE`. The state changes only on the last phase (11). From any state it moves to the kind of a held request if one is pending. Otherwise it moves to the kind of a valid request arriving in that same clock. Otherwise it moves to `CYC_IDLE`. Kind codes: 0 = code fetch, 1 = data read with the 16-bit pointer, 2 = data write with the 16-bit pointer, 3 = data read with the 8-bit pointer, 4 = data write with the 8-bit pointer.

Top module: `ext_bus_seq`

## Requirements
- R1: A machine cycle is exactly 12 clocks. The phase counts 0..11 from reset release. `done` is high for one clock only, in phase 0 of the cycle after a served request.
- R2: In `CYC_IDLE` and `CYC_FETCH` cycles, `ale` is high in phases 1-2 and 7-8, which gives two pulses per cycle.
- R3: In `CYC_READ` and `CYC_WRITE` cycles the second `ale` pulse is dropped (only phases 1-2 are high), and `psen_n` stays high for the whole cycle.
- R4: A fetch of address A keeps `psen_n` low in phases 3-5 and 9-11. It reads byte A in the first half and byte A+1 (modulo 65536) in the second half. `p2_out` shows the high byte of the address in use in each half.
- R5: `p0_oe` is high with the low address byte in phases 0-2 of every non-idle cycle, and also in phases 6-8 of a fetch. It is never high while `psen_n` or `rd_n` is low.
- R6: Data cycles with kinds 1 and 2 put the address high byte on `p2_out`. Kinds 3 and 4 put `p2_latch` on `p2_out`.
- R7: A write keeps `wr_n` low in phases 4-9 and drives `req_wdata` on port 0 in phases 3-11.
- R8: A read keeps `rd_n` low in phases 4-9 and samples `p0_in` at the end of phase 9. `rdata` becomes {8'h00, byte}. A fetch samples at the ends of phases 5 and 11, and `rdata` becomes {byte(A+1), byte(A)}.
- R9: `ale` is never high while `rd_n` or `wr_n` is low. At most one of `psen_n`, `rd_n` and `wr_n` is low at any time.
- R10: A request is served in the cycle that starts at the next boundary. A request raised in phase 11 gives `done` 13 clocks later. A request raised in phase 0 gives `done` 24 clocks later.
- R11: While reset is held, `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `p0_oe`=0, `done`=0 and `rdata`=0.
- R12: An idle cycle leaves `p0_oe` low, drives `p2_latch` on `p2_out` and asserts no strobe.
- R13: A request with a kind code of 5 to 7 is ignored: it gives no `done` and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | One-clock request pulse |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| p2_latch | input | 8 | Port 2 latch contents |
| p0_in | input | 8 | Port 0 input value |
| p0_out | output | 8 | Port 0 output value |
| p0_oe | output | 1 | Port 0 output enable |
| p2_out | output | 8 | Port 2 output value |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| done | output | 1 | Cycle complete pulse |
| rdata | output | 16 | Captured read bytes |

## Verification
The hardest case to reach is a request that arrives in the very clock in which the cycle boundary is taken. At that moment the request goes straight to the state register instead of being held, and that path is easy to get wrong by one whole cycle. The bench follows the phase from reset release and places a pulse exactly in phase 11 and another in phase 0, then checks the two fixed latencies. The walked table also inserts varied idle gaps, so the other requests land on many different phases. Fetches at 00FF and FFFF force the second-half address to carry into, or wrap out of, the high byte.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE,
        CYC_FETCH,
        CYC_READ,
        CYC_WRITE
    } cyc_state_e;

    localparam logic [2:0] KIND_FETCH    = 3'd0;
    localparam logic [2:0] KIND_RD_WIDE  = 3'd1;
    localparam logic [2:0] KIND_WR_WIDE  = 3'd2;
    localparam logic [2:0] KIND_RD_PAGE  = 3'd3;
    localparam logic [2:0] KIND_WR_PAGE  = 3'd4;

    function automatic logic kind_valid(input logic [2:0] k);
        return k <= KIND_WR_PAGE;
    endfunction

    function automatic cyc_state_e kind_state(input logic [2:0] k);
        cyc_state_e s;
        case (k)
            KIND_FETCH:                 s = CYC_FETCH;
            KIND_RD_WIDE, KIND_RD_PAGE: s = CYC_READ;
            KIND_WR_WIDE, KIND_WR_PAGE: s = CYC_WRITE;
            default:                    s = CYC_IDLE;
        endcase
        return s;
    endfunction

    function automatic logic kind_page(input logic [2:0] k);
        return (k == KIND_RD_PAGE) || (k == KIND_WR_PAGE);
    endfunction

endpackage

// File: rtl/bseq_phase_gen.sv
module bseq_phase_gen #(
    parameter int PHASES = 12,
    localparam int PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase,
    output logic          cyc_last
);
    assign cyc_last = (phase == PW'(PHASES - 1));

    always_ff @(posedge clk) begin
        if (rst)           phase <= '0;
        else if (cyc_last) phase <= '0;
        else               phase <= phase + PW'(1);
    end
endmodule

// File: rtl/bseq_cycle_fsm.sv
module bseq_cycle_fsm
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_last,
    input  logic              req,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output cyc_state_e        state,
    output logic              page_mode,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_wdata
);
    logic              pend_v;
    logic [2:0]        pend_kind;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_wdata;

    cyc_state_e        state_nx;
    logic              page_nx;
    logic [ADDR_W-1:0] addr_nx;
    logic [DATA_W-1:0] wdata_nx;
    logic              req_ok;
    logic              take_req;

    assign req_ok   = req && kind_valid(req_kind);
    assign take_req = cyc_last && !pend_v && req_ok;

    always_comb begin
        state_nx = state;
        page_nx  = page_mode;
        addr_nx  = cyc_addr;
        wdata_nx = cyc_wdata;
        if (cyc_last) begin
            if (pend_v) begin
                state_nx = kind_state(pend_kind);
                page_nx  = kind_page(pend_kind);
                addr_nx  = pend_addr;
                wdata_nx = pend_wdata;
            end else if (req_ok) begin
                state_nx = kind_state(req_kind);
                page_nx  = kind_page(req_kind);
                addr_nx  = req_addr;
                wdata_nx = req_wdata;
            end else begin
                state_nx = CYC_IDLE;
                page_nx  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= CYC_IDLE;
            page_mode <= 1'b0;
            cyc_addr  <= '0;
            cyc_wdata <= '0;
        end else begin
            state     <= state_nx;
            page_mode <= page_nx;
            cyc_addr  <= addr_nx;
            cyc_wdata <= wdata_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v     <= 1'b0;
            pend_kind  <= '0;
            pend_addr  <= '0;
            pend_wdata <= '0;
        end else if (req_ok && !take_req) begin
            pend_v     <= 1'b1;
            pend_kind  <= req_kind;
            pend_addr  <= req_addr;
            pend_wdata <= req_wdata;
        end else if (cyc_last && pend_v) begin
            pend_v     <= 1'b0;
        end
    end
endmodule

// File: rtl/bseq_pin_drive.sv
module bseq_pin_drive
    import bseq_pkg::*;
#(
    parameter int PHASES = 12,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int PW   = $clog2(PHASES),
    localparam int HI_W = ADDR_W - DATA_W,
    localparam int HALF = PHASES / 2
) (
    input  cyc_state_e        state,
    input  logic [PW-1:0]     phase,
    input  logic              page_mode,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] cyc_wdata,
    input  logic [HI_W-1:0]   p2_latch,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              p0_oe,
    output logic [DATA_W-1:0] p0_out,
    output logic [HI_W-1:0]   p2_out
);
    logic              ale_a, ale_b, addr_a, addr_b;
    logic              psen_a, psen_b, strobe_win, wdata_win, second;
    logic [ADDR_W-1:0] fetch_addr;
    logic [HI_W-1:0]   data_hi;

    assign addr_a     = phase <= PW'(2);
    assign addr_b     = (phase >= PW'(HALF)) && (phase <= PW'(HALF + 2));
    assign ale_a      = (phase == PW'(1)) || (phase == PW'(2));
    assign ale_b      = (phase == PW'(HALF + 1)) || (phase == PW'(HALF + 2));
    assign psen_a     = (phase >= PW'(3)) && (phase <= PW'(HALF - 1));
    assign psen_b     = phase >= PW'(HALF + 3);
    assign strobe_win = (phase >= PW'(4)) && (phase <= PW'(PHASES - 3));
    assign wdata_win  = phase >= PW'(3);
    assign second     = phase >= PW'(HALF);
    assign fetch_addr = second ? (cyc_addr + ADDR_W'(1)) : cyc_addr;
    assign data_hi    = page_mode ? p2_latch : cyc_addr[ADDR_W-1:DATA_W];

    always_comb begin
        ale    = 1'b0;
        psen_n = 1'b1;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        p0_oe  = 1'b0;
        p0_out = '0;
        p2_out = p2_latch;
        unique case (state)
            CYC_IDLE: begin
                ale = ale_a || ale_b;
            end
            CYC_FETCH: begin
                ale    = ale_a || ale_b;
                psen_n = !(psen_a || psen_b);
                p2_out = fetch_addr[ADDR_W-1:DATA_W];
                if (addr_a || addr_b) begin
                    p0_oe  = 1'b1;
                    p0_out = fetch_addr[DATA_W-1:0];
                end
            end
            CYC_READ: begin
                ale    = ale_a;
                rd_n   = !strobe_win;
                p2_out = data_hi;
                if (addr_a) begin
                    p0_oe  = 1'b1;
                    p0_out = cyc_addr[DATA_W-1:0];
                end
            end
            CYC_WRITE: begin
                ale    = ale_a;
                wr_n   = !strobe_win;
                p2_out = data_hi;
                if (addr_a) begin
                    p0_oe  = 1'b1;
                    p0_out = cyc_addr[DATA_W-1:0];
                end else if (wdata_win) begin
                    p0_oe  = 1'b1;
                    p0_out = cyc_wdata;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bseq_capture.sv
module bseq_capture
    import bseq_pkg::*;
#(
    parameter int PHASES = 12,
    parameter int DATA_W = 8,
    localparam int PW   = $clog2(PHASES),
    localparam int HALF = PHASES / 2
) (
    input  logic                clk,
    input  logic                rst,
    input  cyc_state_e          state,
    input  logic [PW-1:0]       phase,
    input  logic                cyc_last,
    input  logic [DATA_W-1:0]   p0_in,
    output logic [2*DATA_W-1:0] rdata,
    output logic                done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= cyc_last && (state != CYC_IDLE);
            if (state == CYC_FETCH && phase == PW'(HALF - 1))
                rdata[DATA_W-1:0] <= p0_in;
            if (state == CYC_FETCH && phase == PW'(PHASES - 1))
                rdata[2*DATA_W-1:DATA_W] <= p0_in;
            if (state == CYC_READ && phase == PW'(PHASES - 3))
                rdata <= {{DATA_W{1'b0}}, p0_in};
        end
    end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import bseq_pkg::*;
#(
    parameter int PHASES = 12,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int PW   = $clog2(PHASES),
    localparam int HI_W = ADDR_W - DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic [2:0]          req_kind,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [HI_W-1:0]     p2_latch,
    input  logic [DATA_W-1:0]   p0_in,
    output logic [DATA_W-1:0]   p0_out,
    output logic                p0_oe,
    output logic [HI_W-1:0]     p2_out,
    output logic                ale,
    output logic                psen_n,
    output logic                rd_n,
    output logic                wr_n,
    output logic                done,
    output logic [2*DATA_W-1:0] rdata
);
    logic [PW-1:0]     phase;
    logic              cyc_last;
    cyc_state_e        state;
    logic              page_mode;
    logic [ADDR_W-1:0] cyc_addr;
    logic [DATA_W-1:0] cyc_wdata;

    bseq_phase_gen #(.PHASES(PHASES)) u_phase (
        .clk(clk), .rst(rst), .phase(phase), .cyc_last(cyc_last)
    );

    bseq_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst(rst), .cyc_last(cyc_last),
        .req(req), .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .state(state), .page_mode(page_mode), .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata)
    );

    bseq_pin_drive #(.PHASES(PHASES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .state(state), .phase(phase), .page_mode(page_mode),
        .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata), .p2_latch(p2_latch),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .p0_oe(p0_oe), .p0_out(p0_out), .p2_out(p2_out)
    );

    bseq_capture #(.PHASES(PHASES), .DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .state(state), .phase(phase), .cyc_last(cyc_last),
        .p0_in(p0_in), .rdata(rdata), .done(done)
    );
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
    parameter int PHASES = 12,
    localparam int PW = $clog2(PHASES)
) (
    input logic          clk,
    input logic          rst,
    input logic          ale,
    input logic          psen_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic          p0_oe,
    input logic          done,
    input logic [PW-1:0] phase
);
    AST_ALE_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n)); // R9
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!psen_n, !rd_n, !wr_n})); // R9
    AST_OE_QUIET_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (!psen_n || !rd_n) |-> !p0_oe); // R5
    AST_PSEN_NO_ALE: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> !ale); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R1
    AST_DONE_AT_START: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase == '0)); // R1
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (phase == PW'(PHASES - 1)) |=> (phase == '0)); // R1
endmodule

bind ext_bus_seq bseq_checker #(.PHASES(PHASES)) u_chk (
    .clk(clk), .rst(rst), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .p0_oe(p0_oe), .done(done), .phase(phase)
);

// File: tb/tb_ext_bus_seq.sv
`timescale 1ns/1ps
module tb_ext_bus_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  p2_latch = 8'h00;
    logic [7:0]  p0_in, p0_out, p2_out;
    logic        p0_oe, ale, psen_n, rd_n, wr_n, done;
    logic [15:0] rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    logic [7:0] lat_lo = 8'h00;
    assign p0_in = mem_fn({p2_out, lat_lo});

    ext_bus_seq dut (
        .clk(clk), .rst(rst), .req(req), .req_kind(req_kind), .req_addr(req_addr),
        .req_wdata(req_wdata), .p2_latch(p2_latch), .p0_in(p0_in), .p0_out(p0_out),
        .p0_oe(p0_oe), .p2_out(p2_out), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
        .wr_n(wr_n), .done(done), .rdata(rdata)
    );

    // phase of the bus from reset release (R1: 12 clocks per machine cycle)
    int tb_ph = 0;
    always @(posedge clk) begin
        if (rst) tb_ph <= 0;
        else     tb_ph <= (tb_ph == 11) ? 0 : tb_ph + 1;
    end

    // per-cycle monitor
    int c_ale, c_psen, c_rdl, c_wrl, c_ovl, c_oev, c_oe;
    int s_ale, s_psen, s_rdl, s_wrl, s_ovl, s_oev, s_oe;
    int done_cnt = 0;
    logic ale_q = 1'b0, psen_q = 1'b1;
    logic [15:0] w_addr;
    logic [7:0]  w_data;

    always @(negedge clk) begin
        if (ale && !ale_q) c_ale++;
        if (!psen_n && psen_q) c_psen++;
        if (!rd_n) c_rdl++;
        if (!wr_n) begin
            c_wrl++;
            w_addr = {p2_out, lat_lo};
            w_data = p0_out;
        end
        if (ale && (!rd_n || !wr_n)) c_ovl++;
        if (p0_oe && (!psen_n || !rd_n)) c_oev++;
        if (p0_oe) c_oe++;
        if (done) done_cnt++;
        ale_q  = ale;
        psen_q = psen_n;
        if (ale) lat_lo = p0_out;
        if (tb_ph == 11) begin
            s_ale = c_ale; s_psen = c_psen; s_rdl = c_rdl; s_wrl = c_wrl;
            s_ovl = c_ovl; s_oev = c_oev; s_oe = c_oe;
            c_ale = 0; c_psen = 0; c_rdl = 0; c_wrl = 0; c_ovl = 0; c_oev = 0; c_oe = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_ph(input int p);
        do @(negedge clk); while (tb_ph != p);
    endtask

    // issue a request at the current negedge, return clocks until done
    task automatic issue(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd,
                         input logic [7:0] p2l, output int lat);
        req = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; p2_latch = p2l;
        lat = 0;
        do begin
            @(negedge clk);
            req = 1'b0;
            lat++;
        end while (!done && lat < 40);
        #1;
    endtask

    // stimulus / expectation table:
    // {kind[2:0], addr[15:0], wdata[7:0], p2latch[7:0], gap[3:0], ale_exp[1:0], psen_exp[1:0]}
    typedef logic [42:0] vec_t;
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        {3'd0, 16'h1234, 8'h00, 8'hA5, 4'd0,  2'd2, 2'd2},
        {3'd0, 16'h00FF, 8'h00, 8'hA5, 4'd3,  2'd2, 2'd2},
        {3'd0, 16'hFFFF, 8'h00, 8'hA5, 4'd5,  2'd2, 2'd2},
        {3'd1, 16'h8000, 8'h00, 8'h3C, 4'd1,  2'd1, 2'd0},
        {3'd2, 16'hABCD, 8'h5E, 8'h3C, 4'd9,  2'd1, 2'd0},
        {3'd3, 16'h7742, 8'h00, 8'h19, 4'd2,  2'd1, 2'd0},
        {3'd4, 16'h9911, 8'hC3, 8'h6E, 4'd11, 2'd1, 2'd0},
        {3'd1, 16'h0000, 8'h00, 8'h44, 4'd7,  2'd1, 2'd0}
    };

    initial begin
        int lat;
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 ale", {31'd0, ale}, 32'd0);
        chk("R11 psen_n", {31'd0, psen_n}, 32'd1);
        chk("R11 rd_n/wr_n", {30'd0, rd_n, wr_n}, 32'd3);
        chk("R11 p0_oe", {31'd0, p0_oe}, 32'd0);
        chk("R11 done", {31'd0, done}, 32'd0);
        chk("R11 rdata", {16'd0, rdata}, 32'd0);
        p2_latch = 8'h5C;
        rst = 1'b0;

        // R12 / R2: an idle cycle
        wait_ph(11); wait_ph(11); #1;
        chk("R2 idle ale pulses", s_ale, 2);
        chk("R12 idle oe", s_oe, 0);
        chk("R12 idle strobes", s_psen + s_rdl + s_wrl, 0);
        chk("R12 idle p2_out", {24'd0, p2_out}, {24'd0, p2_latch});

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  k;
            logic [15:0] a;
            logic [7:0]  wd, p2l;
            int gap, ae, pe;
            logic [15:0] ea;
            k = VECS[i][42:40]; a = VECS[i][39:24]; wd = VECS[i][23:16];
            p2l = VECS[i][15:8]; gap = VECS[i][7:4]; ae = VECS[i][3:2]; pe = VECS[i][1:0];
            repeat (gap) @(negedge clk);
            issue(k, a, wd, p2l, lat);
            chk($sformatf("R10 latency ok v%0d", i), {31'd0, (lat >= 13 && lat <= 24)}, 32'd1);
            chk($sformatf("R2 R3 ale pulses v%0d", i), s_ale, ae);
            chk($sformatf("R3 R4 psen pulses v%0d", i), s_psen, pe);
            chk($sformatf("R9 ale/strobe overlap v%0d", i), s_ovl, 0);
            chk($sformatf("R5 oe while sampling v%0d", i), s_oev, 0);
            ea = (k == 3'd3 || k == 3'd4) ? {p2l, a[7:0]} : a;
            case (k)
                3'd0: chk($sformatf("R4 R8 fetch rdata v%0d", i), {16'd0, rdata},
                          {16'd0, mem_fn(a + 16'd1), mem_fn(a)});
                3'd1, 3'd3: begin
                    chk($sformatf("R6 R8 read rdata v%0d", i), {16'd0, rdata},
                        {24'd0, mem_fn(ea)});
                    chk($sformatf("R8 rd_n low clocks v%0d", i), s_rdl, 6);
                end
                default: begin
                    chk($sformatf("R7 wr_n low clocks v%0d", i), s_wrl, 6);
                    chk($sformatf("R6 write address v%0d", i), {16'd0, w_addr}, {16'd0, ea});
                    chk($sformatf("R7 write data v%0d", i), {24'd0, w_data}, {24'd0, wd});
                end
            endcase
            @(negedge clk);
            chk($sformatf("R1 done one clock v%0d", i), {31'd0, done}, 32'd0);
        end

        // R10: request raised in phase 11 starts right away
        wait_ph(11);
        issue(3'd0, 16'h2468, 8'h00, 8'h00, lat);
        chk("R10 latency from phase 11", lat, 13);
        chk("R4 fetch rdata phase11", {16'd0, rdata}, {16'd0, mem_fn(16'h2469), mem_fn(16'h2468)});

        // R10: request raised in phase 0 waits for the next boundary
        wait_ph(0);
        issue(3'd1, 16'h1357, 8'h00, 8'h00, lat);
        chk("R10 latency from phase 0", lat, 24);

        // R13: reserved kind is ignored
        wait_ph(4);
        begin
            int d0;
            d0 = done_cnt;
            req = 1'b1; req_kind = 3'd6; req_addr = 16'h4321;
            @(negedge clk); req = 1'b0;
            wait_ph(11); wait_ph(11); #1;
            chk("R13 no done", done_cnt - d0, 0);
            chk("R13 no strobes", s_psen + s_rdl + s_wrl, 0);
            chk("R13 stays idle oe", s_oe, 0);
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule